// File: doc/BRIEF.md
# Window Watchdog with Limits

This block is a window-style watchdog timer. A free-running up-counter starts from zero after every service strobe, and each count is judged against three programmable thresholds. A service that arrives too early, before the lower threshold, is treated as a fault. A counter that climbs to the upper threshold without being serviced is also treated as a fault. An intermediate warn threshold can raise a sticky interrupt so that software gets notice before the upper threshold expires. Each threshold has its own action selection. The lower and upper thresholds either do nothing or request a reset. The warn threshold either does nothing or sets the interrupt.

Software configures the block through a simple write-only register port. A self-service option makes the counter restart on its own at the upper threshold instead of faulting. Three pause controls freeze the counter: one for deep sleep, one for hibernate, and one for CPU debug halt. The reset request is a registered single-cycle pulse. The warn interrupt is a registered level that software clears by writing a one.

Top module: `window_watchdog`

## Requirements
- R1: After synchronous reset, `rst_req` and `warn_irq` are 0, the counter is disabled, all control and action bits are 0, and the thresholds are lower = `DEF_LOWER` (0), upper = `DEF_UPPER` (32000 by default), warn = `DEF_WARN` (0).
- R2: Register writes (`wr_en` high at a clock edge) take effect at that edge. The address map is:
  - address 0: control. Bit 0 enables the counter, bit 1 enables self-service, bit 2 pauses in deep sleep, bit 3 pauses in hibernate, bit 4 lets the counter run during debug halt.
  - address 1: lower threshold.
  - address 2: upper threshold.
  - address 3: warn threshold.
  - address 4: actions. Bit 0 makes a lower fault request a reset, bit 1 makes an upper fault request a reset, bit 2 makes a warn hit set the interrupt.
  - address 5: interrupt clear.
  - Writes to addresses 6 and 7 change nothing.
- R3: While enabled, running and not serviced, the counter rises by one per clock. While disabled, it is held at zero and `rst_req` stays 0.
- R4: A service strobe at a clock edge while enabled clears the counter to zero, whether or not the counter is paused.
- R5: A service while the counter is below the lower threshold, with lower action 1, gives a one-cycle `rst_req` in the next cycle. With lower action 0, or with the counter at or above the lower threshold, the service gives no reset request.
- R6: When a running, unserviced counter is at or above the upper threshold, it restarts at zero. If upper action is 1 and self-service is 0, `rst_req` pulses for one cycle in the next cycle. This holds for an upper threshold at the counter's all-ones value, and for an upper threshold rewritten below the current count.
- R7: With self-service set, reaching the upper threshold restarts the counter and never requests a reset, whatever the upper action is.
- R8: When a running, unserviced counter equals the warn threshold and warn action is 1, `warn_irq` is 1 from the next cycle on. It stays 1 until a write to address 5 with data bit 0 = 1. A write there with bit 0 = 0 has no effect. A new set in the same cycle as a clear wins.
- R9: With control bit 2 set and `in_deepsleep` high, or with control bit 3 set and `in_hibernate` high, the counter holds its value. With the control bit clear, the matching input has no effect.
- R10: With `cpu_halted` high and control bit 4 = 0, the counter holds. With control bit 4 = 1, it keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| svc | input | 1 | Service strobe, one clock per service |
| in_deepsleep | input | 1 | System is in deep sleep |
| in_hibernate | input | 1 | System is in hibernate |
| cpu_halted | input | 1 | CPU is halted for debug |
| rst_req | output | 1 | Reset request pulse |
| warn_irq | output | 1 | Sticky warn interrupt |

## Verification
The bench builds the block with a 12-bit counter, 16-bit write data and an upper default of 40. This puts an unserviced expiry within about forty clocks. It also puts the all-ones upper threshold (4095) within a few thousand clocks, so the no-wrap case at the counter's top is reached. Windowed service, early service under both lower-action settings, and warn set/clear races all fall in short sequences. The pause inputs are held for periods longer than the upper threshold, which shows that expiry is only deferred.

// File: rtl/winwd_pkg.sv
package winwd_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_LOWER  = 3'd1,
    REG_UPPER  = 3'd2,
    REG_WARN   = 3'd3,
    REG_ACTION = 3'd4,
    REG_IRQCLR = 3'd5
  } reg_addr_e;

  // control word, bit 0 is enable
  typedef struct packed {
    logic dbg_run;
    logic pause_hib;
    logic pause_ds;
    logic auto_svc;
    logic enable;
  } ctrl_t;

  // action word, bit 0 is lower-fault reset
  typedef struct packed {
    logic warn_irq;
    logic upper_rst;
    logic lower_rst;
  } action_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ACT_W  = $bits(action_t);

endpackage

// File: rtl/winwd_regs.sv
module winwd_regs
  import winwd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int DEF_LOWER = 0,
  parameter int DEF_UPPER = 32000,
  parameter int DEF_WARN  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output action_t           act,
  output logic [CNT_W-1:0]  lim_lower,
  output logic [CNT_W-1:0]  lim_upper,
  output logic [CNT_W-1:0]  lim_warn,
  output logic              irq_clr
);

  localparam int NUM_LIM  = 3;
  localparam int LIM_BASE = int'(REG_LOWER);
  localparam logic [CNT_W-1:0] LIM_DEF [NUM_LIM] =
    '{CNT_W'(DEF_LOWER), CNT_W'(DEF_UPPER), CNT_W'(DEF_WARN)};

  ctrl_t            ctrl_q;
  action_t          act_q;
  logic [CNT_W-1:0] lim_q [NUM_LIM];
  logic             unused_wdata;

  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == REG_CTRL) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (wr_en && wr_addr == REG_ACTION) begin
      act_q <= action_t'(wr_data[ACT_W-1:0]);
    end
  end

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        lim_q[g] <= LIM_DEF[g];
      end else if (wr_en && wr_addr == REG_AW'(LIM_BASE + g)) begin
        lim_q[g] <= wr_data[CNT_W-1:0];
      end
    end
  end

  assign ctrl      = ctrl_q;
  assign act       = act_q;
  assign lim_lower = lim_q[0];
  assign lim_upper = lim_q[1];
  assign lim_warn  = lim_q[2];
  assign irq_clr   = wr_en && (wr_addr == REG_IRQCLR) && wr_data[0];

endmodule

// File: rtl/winwd_gate.sv
module winwd_gate
  import winwd_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  in_deepsleep,
  input  logic  in_hibernate,
  input  logic  cpu_halted,
  output logic  run
);

  logic hold_ds;
  logic hold_hib;
  logic hold_dbg;

  always_comb begin
    hold_ds  = ctrl.pause_ds && in_deepsleep;
    hold_hib = ctrl.pause_hib && in_hibernate;
    hold_dbg = !ctrl.dbg_run && cpu_halted;
    run      = ctrl.enable && !(hold_ds || hold_hib || hold_dbg);
  end

endmodule

// File: rtl/winwd_core.sv
module winwd_core
  import winwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  action_t          act,
  input  logic [CNT_W-1:0] lim_lower,
  input  logic [CNT_W-1:0] lim_upper,
  input  logic [CNT_W-1:0] lim_warn,
  input  logic             run,
  input  logic             svc,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             warn_irq
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;
  logic             irq_q, irq_d;
  logic             early_svc;
  logic             expired;
  logic             warn_hit;

  always_comb begin
    early_svc = cnt_q < lim_lower;
    expired   = cnt_q >= lim_upper;
    warn_hit  = cnt_q == lim_warn;
  end

  always_comb begin
    cnt_d = cnt_q;
    rst_d = 1'b0;
    irq_d = irq_q && !irq_clr;
    if (!ctrl.enable) begin
      cnt_d = '0;
    end else if (svc) begin
      cnt_d = '0;
      rst_d = act.lower_rst && early_svc;
    end else if (run) begin
      if (expired) begin
        cnt_d = '0;
        rst_d = act.upper_rst && !ctrl.auto_svc;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (act.warn_irq && warn_hit) begin
        irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
      irq_q <= irq_d;
    end
  end

  assign cnt      = cnt_q;
  assign rst_req  = rst_q;
  assign warn_irq = irq_q;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import winwd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int DEF_LOWER = 0,
  parameter int DEF_UPPER = 32000,
  parameter int DEF_WARN  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              svc,
  input  logic              in_deepsleep,
  input  logic              in_hibernate,
  input  logic              cpu_halted,
  output logic              rst_req,
  output logic              warn_irq
);

  ctrl_t            ctrl_w;
  action_t          act_w;
  logic [CNT_W-1:0] lo_w, up_w, warn_w, cnt_w;
  logic             irq_clr_w;
  logic             run_w;

  winwd_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_LOWER(DEF_LOWER),
    .DEF_UPPER(DEF_UPPER), .DEF_WARN(DEF_WARN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl_w), .act(act_w), .lim_lower(lo_w), .lim_upper(up_w),
    .lim_warn(warn_w), .irq_clr(irq_clr_w)
  );

  winwd_gate u_gate (
    .ctrl(ctrl_w), .in_deepsleep(in_deepsleep), .in_hibernate(in_hibernate),
    .cpu_halted(cpu_halted), .run(run_w)
  );

  winwd_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl_w), .act(act_w),
    .lim_lower(lo_w), .lim_upper(up_w), .lim_warn(warn_w),
    .run(run_w), .svc(svc), .irq_clr(irq_clr_w),
    .cnt(cnt_w), .rst_req(rst_req), .warn_irq(warn_irq)
  );

endmodule

// File: rtl/winwd_checker.sv
module winwd_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             auto_svc,
  input logic             dbg_run,
  input logic             act_lo,
  input logic             act_up,
  input logic             svc,
  input logic             run,
  input logic             halted,
  input logic             irq_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lo,
  input logic [CNT_W-1:0] up,
  input logic             rst_req,
  input logic             warn_irq
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!rst_req && !warn_irq)); // R1
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst) !en |=> cnt == '0); // R3
  AST_OFF_NO_RESET: assert property (@(posedge clk) disable iff (rst) !en |=> !rst_req); // R3
  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst) (en && svc) |=> cnt == '0); // R4
  AST_EARLY_SVC_RESET: assert property (@(posedge clk) disable iff (rst) (en && svc && act_lo && cnt < lo) |=> rst_req); // R5
  AST_LATE_SVC_QUIET: assert property (@(posedge clk) disable iff (rst) (en && svc && !(cnt < lo)) |=> !rst_req); // R5
  AST_UPPER_RESET: assert property (@(posedge clk) disable iff (rst) (en && !svc && run && cnt >= up && act_up && !auto_svc) |=> rst_req); // R6
  AST_AUTO_QUIET: assert property (@(posedge clk) disable iff (rst) (en && !svc && auto_svc) |=> !rst_req); // R7
  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst) (warn_irq && !irq_clr) |=> warn_irq); // R8
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst) (en && !svc && !run) |=> $stable(cnt)); // R9
  AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (rst) (en && !svc && halted && !dbg_run) |=> $stable(cnt)); // R10

endmodule

bind window_watchdog winwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(ctrl_w.enable), .auto_svc(ctrl_w.auto_svc),
  .dbg_run(ctrl_w.dbg_run), .act_lo(act_w.lower_rst), .act_up(act_w.upper_rst),
  .svc(svc), .run(run_w), .halted(cpu_halted), .irq_clr(irq_clr_w),
  .cnt(cnt_w), .lo(lo_w), .up(up_w), .rst_req(rst_req), .warn_irq(warn_irq)
);

// File: tb/window_watchdog_bench.sv
`timescale 1ns/1ps
module window_watchdog_bench;

  localparam int CNT_W  = 12;
  localparam int DATA_W = 16;
  localparam int UP_DEF = 40;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic svc = 1'b0, in_deepsleep = 1'b0, in_hibernate = 1'b0, cpu_halted = 1'b0;
  logic rst_req, warn_irq;

  always #10 clk = ~clk;

  window_watchdog #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_LOWER(0), .DEF_UPPER(UP_DEF), .DEF_WARN(0)
  ) u_window_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .svc(svc), .in_deepsleep(in_deepsleep), .in_hibernate(in_hibernate),
    .cpu_halted(cpu_halted), .rst_req(rst_req), .warn_irq(warn_irq)
  );

  // behavioural reference
  int m_ctrl, m_act, m_lo, m_up, m_warn, m_cnt;
  bit m_rst, m_irq, m_valid;
  int n_cmp = 0, n_bad = 0, n_rst_seen = 0, n_irq_seen = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_act = 0; m_lo = 0; m_up = UP_DEF; m_warn = 0;
      m_cnt = 0; m_rst = 0; m_irq = 0; m_valid = 1;
    end else begin
      bit running, nr, clr;
      int nc;
      running = m_ctrl[0] && !(m_ctrl[2] && in_deepsleep) && !(m_ctrl[3] && in_hibernate)
                && !(!m_ctrl[4] && cpu_halted);
      clr = wr_en && wr_addr == 3'd5 && wr_data[0];
      nr = 0;
      nc = m_cnt;
      if (clr) m_irq = 0;
      if (!m_ctrl[0]) nc = 0;
      else if (svc) begin
        nc = 0;
        if (m_act[0] && m_cnt < m_lo) nr = 1;
      end else if (running) begin
        if (m_cnt >= m_up) begin
          nc = 0;
          if (m_act[1] && !m_ctrl[1]) nr = 1;
        end else nc = m_cnt + 1;
        if (m_act[2] && m_cnt == m_warn) m_irq = 1;
      end
      m_cnt = nc;
      m_rst = nr;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = int'(wr_data) & 31;
          3'd1: m_lo   = int'(wr_data) & MAXV;
          3'd2: m_up   = int'(wr_data) & MAXV;
          3'd3: m_warn = int'(wr_data) & MAXV;
          3'd4: m_act  = int'(wr_data) & 7;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      n_cmp++;
      if (rst_req !== m_rst) begin
        n_bad++;
        $display("FAIL %s rst_req actual %0b expected %0b at %0t", cur_req, rst_req, m_rst, $time);
      end
      n_cmp++;
      if (warn_irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s warn_irq actual %0b expected %0b at %0t", cur_req, warn_irq, m_irq, $time);
      end
      if (rst_req === 1'b1) n_rst_seen++;
      if (warn_irq === 1'b1) n_irq_seen++;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DATA_W'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic serve();
    svc = 1'b1;
    tick();
    svc = 1'b0;
  endtask

  task automatic expect_seen(string tag, int got, bit want);
    n_cmp++;
    if ((got != 0) != want) begin
      n_bad++;
      $display("FAIL %s event seen actual %0d expected %0b", tag, got, want);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1: quiet out of reset, default upper not reached while disabled
    cur_req = "R1";
    tick(60);

    // R3: enabled, upper action on, expiry after default upper
    cur_req = "R3";
    wr(4, 2);
    n_rst_seen = 0;
    wr(0, 1);
    tick(45);
    expect_seen("R3", n_rst_seen, 1);

    // R4: windowed service keeps it quiet
    cur_req = "R4";
    serve();
    n_rst_seen = 0;
    for (int k = 0; k < 6; k++) begin tick(20); serve(); end
    expect_seen("R4", n_rst_seen, 0);

    // R5: early service faults when lower action set
    cur_req = "R5";
    wr(1, 10); wr(4, 3); serve();
    n_rst_seen = 0;
    tick(4); serve(); tick(2);
    expect_seen("R5", n_rst_seen, 1);
    n_rst_seen = 0;
    tick(15); serve(); tick(2);
    expect_seen("R5", n_rst_seen, 0);
    wr(4, 2); serve();
    n_rst_seen = 0;
    tick(3); serve(); tick(2);
    expect_seen("R5", n_rst_seen, 0);
    wr(1, 0);

    // R7: self-service never requests reset
    cur_req = "R7";
    wr(0, 3);
    n_rst_seen = 0;
    tick(130);
    expect_seen("R7", n_rst_seen, 0);

    // R6: upper lowered below current count, then all-ones upper
    cur_req = "R6";
    wr(0, 1); serve();
    tick(30);
    n_rst_seen = 0;
    wr(2, 10); tick(3);
    expect_seen("R6", n_rst_seen, 1);
    wr(2, MAXV); serve();
    n_rst_seen = 0;
    tick(MAXV - 5);
    expect_seen("R6", n_rst_seen, 0);
    tick(12);
    expect_seen("R6", n_rst_seen, 1);
    wr(2, UP_DEF); serve();

    // R8: warn sticky, W1C, zero write ignored
    cur_req = "R8";
    wr(3, 7); wr(4, 4); serve();
    n_irq_seen = 0;
    tick(12);
    expect_seen("R8", n_irq_seen, 1);
    wr(5, 0); tick(50);
    wr(5, 1); tick(2);
    serve(); tick(3);
    wr(5, 1); tick(3);
    serve(); tick(6);
    wr(5, 1); tick(4);
    wr(4, 2);

    // R9: sleep pauses defer expiry; pause bit clear means no effect
    cur_req = "R9";
    wr(0, 1 | 4); serve();
    in_deepsleep = 1'b1; n_rst_seen = 0;
    tick(100);
    expect_seen("R9", n_rst_seen, 0);
    in_deepsleep = 1'b0; tick(45);
    expect_seen("R9", n_rst_seen, 1);
    wr(0, 1 | 8); serve();
    in_hibernate = 1'b1; in_deepsleep = 1'b1; n_rst_seen = 0;
    tick(100);
    expect_seen("R9", n_rst_seen, 0);
    in_hibernate = 1'b0; tick(45);
    expect_seen("R9", n_rst_seen, 1);
    in_deepsleep = 1'b0;
    tick(20); in_deepsleep = 1'b1; serve(); tick(15); serve(); in_deepsleep = 1'b0;

    // R10: debug halt holds unless debug-run set
    cur_req = "R10";
    wr(0, 1); serve();
    cpu_halted = 1'b1; n_rst_seen = 0;
    tick(100);
    expect_seen("R10", n_rst_seen, 0);
    wr(0, 1 | 16); n_rst_seen = 0;
    tick(45);
    expect_seen("R10", n_rst_seen, 1);
    cpu_halted = 1'b0;

    // R2: unused addresses change nothing; R3 disable holds zero
    cur_req = "R2";
    wr(6, 16'hFFFF); wr(7, 16'hFFFF); serve();
    tick(50);
    cur_req = "R3";
    wr(0, 0); n_rst_seen = 0;
    tick(100);
    expect_seen("R3", n_rst_seen, 0);
    wr(0, 1); tick(50);

    // R1: reset mid-run returns to quiet state
    cur_req = "R1";
    wr(4, 7); wr(0, 1); tick(5);
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(60);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule